// File: doc/BRIEF.md
# Watermark Byte Queue with Latched Interrupts

This block is a 24-entry byte queue that sits between a host and a protocol engine. In the transmit direction the host loads bytes and the engine drains them. In the receive direction the engine loads framed bytes and the host drains them. Both sides have their own push and pop strobes. The oldest byte is always visible on a single head output.

The block reports its fill level and a set of status flags. A low watermark is meaningful while transmitting and a high watermark is meaningful while receiving. Overflow and underflow are recorded as sticky flags. Each of the four conditions also latches a bit in an interrupt register. The host clears that register by reading it, and the interrupt line is the OR of the latched bits that are enabled by a mask.

A clear strobe, a low enable input or the power-on reset empties the queue. Any of them also zeroes the level, the sticky flags and the interrupt register.

Top module: `wm_byte_fifo`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle with `enable` low, `level` is 0, `flag_ovf` and `flag_udf` are 0, `irq_reg` is 0 and `irq` is 0.
- R2: Bytes leave in the order they were accepted, and `rd_data` shows the oldest stored byte. When `host_push` and `eng_push` are both high in one cycle, only `host_wdata` is stored. Either pop strobe removes one byte.
- R3: A push while `level` is 24 with no pop in the same cycle is discarded. `level` stays 24, `flag_ovf` is set and stays set, and `irq_reg` bit 2 is latched.
- R4: A pop while `level` is 0 changes nothing stored. `flag_udf` is set and stays set, and `irq_reg` bit 3 is latched.
- R5: `level` rises by one on an accepted push and falls by one on an accepted pop. It is unchanged when both are accepted in one cycle, and it never exceeds 24.
- R6: `flag_low` is high when `tx_mode` is 1 and `level` is 6 or less. A pop in transmit mode that takes `level` from 7 to 6 latches `irq_reg` bit 0.
- R7: `flag_high` is high when `tx_mode` is 0 and `level` is above 18. A push in receive mode that takes `level` from 18 to 19 latches `irq_reg` bit 1.
- R8: A cycle with `irq_rd` high still shows the latched bits. In the next cycle they are cleared, except for bits whose event occurred in the read cycle.
- R9: `irq` is high exactly when some bit of `irq_reg` is set and its bit in `irq_mask` is 1. The mask does not stop bits from latching.
- R10: A `clear` cycle empties the queue, sets `level` to 0, clears `flag_ovf`, `flag_udf` and `irq_reg`, and ignores any push or pop in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| enable | input | 1 | Block enable; while low, the block is held empty and its status is cleared |
| tx_mode | input | 1 | 1 = transmit direction, 0 = receive direction |
| clear | input | 1 | Synchronous flush strobe |
| host_push | input | 1 | Host write strobe; has priority over the engine write |
| host_wdata | input | 8 | Host write byte |
| host_pop | input | 1 | Host read strobe |
| eng_push | input | 1 | Engine write strobe |
| eng_wdata | input | 8 | Engine write byte |
| eng_pop | input | 1 | Engine read strobe |
| rd_data | output | 8 | Oldest stored byte |
| level | output | 5 | Number of stored bytes |
| flag_low | output | 1 | Transmit low watermark reached |
| flag_high | output | 1 | Receive high watermark exceeded |
| flag_ovf | output | 1 | Sticky overflow flag |
| flag_udf | output | 1 | Sticky underflow flag |
| irq_mask | input | 4 | Interrupt enables: bit 0 low, bit 1 high, bit 2 overflow, bit 3 underflow |
| irq_rd | input | 1 | Host read of the interrupt register; clears it afterwards |
| irq_reg | output | 4 | Latched interrupt bits, same bit order as `irq_mask` |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach are the two watermark crossings and the overflow. They only happen at exact fill levels, in the right direction, and with a single strobe active. The stimulus therefore fills the queue one byte at a time in receive mode, checking the level just below and just above 18, and keeps pushing until a byte is refused at 24. It then switches to transmit mode without emptying the queue and drains it through 7 and 6. A scoreboard queue follows every accepted byte, so the discarded overflow byte and the dropped engine byte in a dual-push cycle both show up as order mismatches if the design stores them. A read of the interrupt register coinciding with a fresh underflow covers the case where a new event and the clear-on-read happen in the same cycle.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;

    // Interrupt source vector; bit order matches irq_mask / irq_reg ports.
    typedef struct packed {
        logic udf;   // bit 3
        logic ovf;   // bit 2
        logic high;  // bit 1
        logic low;   // bit 0
    } wm_irq_t;

    localparam int IRQ_W = 4;

endpackage

// File: rtl/wm_fifo_mem.sv
module wm_fifo_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 24
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/wm_fifo_ctrl.sv
module wm_fifo_ctrl
    import wm_fifo_pkg::*;
#(
    parameter int DEPTH     = 24,
    parameter int LOW_MARK  = 6,
    parameter int HIGH_MARK = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       tx_mode,
    input  logic                       push,
    input  logic                       pop,
    output logic                       we,
    output logic [$clog2(DEPTH)-1:0]   wptr,
    output logic [$clog2(DEPTH)-1:0]   rptr,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf_flag,
    output logic                       udf_flag,
    output wm_irq_t                    events
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovf;
        logic          udf;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    wm_irq_t ev_d;
    logic    do_push, do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        ev_d    = '0;
        do_pop  = pop && (st_q.count != '0);
        do_push = push && ((int'(st_q.count) != DEPTH) || do_pop);
        if (flush) begin
            st_d    = '0;
            do_push = 1'b0;
            do_pop  = 1'b0;
        end else begin
            if (do_push) st_d.wptr = step_ptr(st_q.wptr);
            if (do_pop)  st_d.rptr = step_ptr(st_q.rptr);
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
            if (push && !do_push) begin
                st_d.ovf = 1'b1;
                ev_d.ovf = 1'b1;
            end
            if (pop && !do_pop) begin
                st_d.udf = 1'b1;
                ev_d.udf = 1'b1;
            end
            ev_d.low  = tx_mode && do_pop && !do_push
                        && (int'(st_q.count) == LOW_MARK + 1);
            ev_d.high = !tx_mode && do_push && !do_pop
                        && (int'(st_q.count) == HIGH_MARK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we       = do_push;
    assign wptr     = st_q.wptr;
    assign rptr     = st_q.rptr;
    assign count    = st_q.count;
    assign ovf_flag = st_q.ovf;
    assign udf_flag = st_q.udf;
    assign events   = ev_d;

endmodule

// File: rtl/wm_fifo_irq.sv
module wm_fifo_irq
    import wm_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  wm_irq_t    events,
    input  logic       rd,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] latched,
    output logic       irq
);
    wm_irq_t irq_d, irq_q;

    always_comb begin
        if (flush) irq_d = '0;
        else       irq_d = (rd ? wm_irq_t'('0) : irq_q) | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign latched = irq_q;
    assign irq     = |(irq_q & mask);

endmodule

// File: rtl/wm_byte_fifo.sv
module wm_byte_fifo
    import wm_fifo_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DEPTH     = 24,
    parameter int LOW_MARK  = 6,
    parameter int HIGH_MARK = 18
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       tx_mode,
    input  logic                       clear,
    input  logic                       host_push,
    input  logic [DW-1:0]              host_wdata,
    input  logic                       host_pop,
    input  logic                       eng_push,
    input  logic [DW-1:0]              eng_wdata,
    input  logic                       eng_pop,
    output logic [DW-1:0]              rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       flag_low,
    output logic                       flag_high,
    output logic                       flag_ovf,
    output logic                       flag_udf,
    input  logic [3:0]                 irq_mask,
    input  logic                       irq_rd,
    output logic [3:0]                 irq_reg,
    output logic                       irq
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          flush, push, pop, we;
    logic [DW-1:0] wdata;
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    wm_irq_t       events;

    assign flush = clear || !enable;
    assign push  = host_push || eng_push;
    assign pop   = host_pop || eng_pop;
    assign wdata = host_push ? host_wdata : eng_wdata;

    wm_fifo_ctrl #(
        .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .tx_mode(tx_mode),
        .push(push), .pop(pop), .we(we), .wptr(wptr), .rptr(rptr),
        .count(count), .ovf_flag(flag_ovf), .udf_flag(flag_udf),
        .events(events)
    );

    wm_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(we), .waddr(wptr), .wdata(wdata),
        .raddr(rptr), .rdata(rd_data)
    );

    wm_fifo_irq u_irq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .events(events),
        .rd(irq_rd), .mask(irq_mask), .latched(irq_reg), .irq(irq)
    );

    assign level     = count;
    assign flag_low  = tx_mode && (int'(count) <= LOW_MARK);
    assign flag_high = !tx_mode && (int'(count) > HIGH_MARK);

endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
    parameter int DEPTH     = 24,
    parameter int LOW_MARK  = 6,
    parameter int HIGH_MARK = 18
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       tx_mode,
    input logic                       clear,
    input logic                       host_push,
    input logic                       host_pop,
    input logic                       eng_push,
    input logic                       eng_pop,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       flag_ovf,
    input logic                       flag_udf,
    input logic                       irq_rd,
    input logic [3:0]                 irq_reg
);
    logic any_push, any_pop, run;
    assign any_push = host_push || eng_push;
    assign any_pop  = host_pop || eng_pop;
    assign run      = enable && !clear;

    // R1 and R10: flush leaves the block empty and quiet
    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || !enable) |=> (level == 0 && irq_reg == 0 && !flag_ovf && !flag_udf));

    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    assert_pushpop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && any_push && any_pop && level != 0 && int'(level) < DEPTH) |=> $stable(level));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && any_push && !any_pop && int'(level) == DEPTH)
        |=> (int'(level) == DEPTH && flag_ovf && irq_reg[2]));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && any_pop && !any_push && level == 0)
        |=> (level == 0 && flag_udf && irq_reg[3]));

    assert_low_cross_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tx_mode && any_pop && !any_push && int'(level) == LOW_MARK + 1)
        |=> (int'(level) == LOW_MARK && irq_reg[0]));

    assert_high_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tx_mode && any_push && !any_pop && int'(level) == HIGH_MARK)
        |=> (int'(level) == HIGH_MARK + 1 && irq_reg[1]));

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rd && !any_push && !any_pop) |=> (irq_reg == 0));

endmodule

bind wm_byte_fifo wm_fifo_chk #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode),
    .clear(clear), .host_push(host_push), .host_pop(host_pop),
    .eng_push(eng_push), .eng_pop(eng_pop), .level(level),
    .flag_ovf(flag_ovf), .flag_udf(flag_udf), .irq_rd(irq_rd),
    .irq_reg(irq_reg)
);

// File: tb/test_wm_byte_fifo.sv
module test_wm_byte_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0, enable = 1'b1, tx_mode = 1'b0, clear = 1'b0;
    logic host_push = 1'b0, host_pop = 1'b0, eng_push = 1'b0, eng_pop = 1'b0;
    logic [7:0] host_wdata = '0, eng_wdata = '0;
    logic [3:0] irq_mask = 4'hF;
    logic irq_rd = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic flag_low, flag_high, flag_ovf, flag_udf, irq;
    logic [3:0] irq_reg;

    int n_chk = 0, n_bad = 0;
    logic [7:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wm_byte_fifo i_wm_byte_fifo (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode),
        .clear(clear), .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .eng_push(eng_push), .eng_wdata(eng_wdata),
        .eng_pop(eng_pop), .rd_data(rd_data), .level(level),
        .flag_low(flag_low), .flag_high(flag_high), .flag_ovf(flag_ovf),
        .flag_udf(flag_udf), .irq_mask(irq_mask), .irq_rd(irq_rd),
        .irq_reg(irq_reg), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each accepted pop must present the oldest expected byte (R2).
    always @(negedge clk) begin
        if (rst_n && enable && !clear && (host_pop || eng_pop) && sb_q.size() > 0) begin
            check("R2 order", int'(rd_data), int'(sb_q.pop_front()));
        end
    end

    // Driver: one cycle of strobes; inputs change just after a rising edge.
    task automatic op(input logic hp, input logic [7:0] hd, input logic ep,
                      input logic [7:0] ed, input logic hpop, input logic epop);
        host_push = hp; host_wdata = hd; eng_push = ep; eng_wdata = ed;
        host_pop = hpop; eng_pop = epop;
        if ((hp || ep) && (sb_q.size() < DEPTH || ((hpop || epop) && sb_q.size() > 0)))
            sb_q.push_back(hp ? hd : ed);
        @(posedge clk); #1;
        host_push = 0; eng_push = 0; host_pop = 0; eng_pop = 0;
    endtask

    task automatic read_irq();
        irq_rd = 1'b1;
        @(posedge clk); #1;
        irq_rd = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        check("R1 level in reset", int'(level), 0);
        check("R1 irq_reg in reset", int'(irq_reg), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 irq after reset", int'(irq), 0);
        check("R1 ovf/udf after reset", int'({flag_ovf, flag_udf}), 0);

        // R2 / R5: mixed ports, dual push, push+pop
        op(1, 8'h11, 0, 0, 0, 0);
        op(0, 0, 1, 8'h22, 0, 0);
        op(1, 8'h33, 1, 8'h44, 0, 0);
        check("R5 level after 3 pushes", int'(level), 3);
        op(0, 0, 1, 8'h55, 1, 0);
        check("R5 level push+pop", int'(level), 3);
        op(0, 0, 0, 0, 0, 1);
        op(0, 0, 0, 0, 1, 0);
        op(0, 0, 0, 0, 0, 1);
        check("R5 level drained", int'(level), 0);
        check("R2 no irq in normal use", int'(irq_reg), 0);

        // R4 underflow, R8 read clear
        op(0, 0, 0, 0, 1, 0);
        check("R4 level after empty pop", int'(level), 0);
        check("R4 udf flag", int'(flag_udf), 1);
        check("R4 irq bit3", int'(irq_reg), 8);
        check("R9 irq line", int'(irq), 1);
        irq_rd = 1'b1; #1;
        check("R8 bits visible during read", int'(irq_reg), 8);
        @(posedge clk); #1; irq_rd = 1'b0;
        check("R8 cleared after read", int'(irq_reg), 0);
        check("R8 irq dropped", int'(irq), 0);
        check("R4 udf sticky", int'(flag_udf), 1);

        // R9 masking
        irq_mask = 4'b0111;
        op(0, 0, 0, 0, 1, 0);
        check("R9 masked bit latched", int'(irq_reg), 8);
        check("R9 masked line low", int'(irq), 0);
        irq_mask = 4'hF; #1;
        check("R9 unmasked line high", int'(irq), 1);
        // R8: new event in the read cycle survives
        irq_rd = 1'b1;
        op(0, 0, 0, 0, 0, 1);
        irq_rd = 1'b0;
        check("R8 event wins over read", int'(irq_reg), 8);
        read_irq();

        // R10 clear
        op(1, 8'hA1, 0, 0, 0, 0);
        op(1, 8'hA2, 0, 0, 0, 0);
        clear = 1'b1;
        op(1, 8'hA3, 0, 0, 0, 0);
        clear = 1'b0;
        sb_q.delete();
        check("R10 level", int'(level), 0);
        check("R10 udf cleared", int'(flag_udf), 0);
        check("R10 irq_reg cleared", int'(irq_reg), 0);

        // R7 high watermark, R3 overflow (receive)
        tx_mode = 1'b0;
        for (int i = 0; i < 18; i++) op(0, 0, 1, 8'(8'h40 + i), 0, 0);
        check("R7 level 18", int'(level), 18);
        check("R7 no high flag at 18", int'(flag_high), 0);
        check("R7 no high irq at 18", int'(irq_reg), 0);
        op(0, 0, 1, 8'h52, 0, 0);
        check("R7 high flag at 19", int'(flag_high), 1);
        check("R7 high irq", int'(irq_reg), 2);
        for (int i = 0; i < 5; i++) op(0, 0, 1, 8'(8'h60 + i), 0, 0);
        check("R3 full level", int'(level), 24);
        check("R3 ovf clear before", int'(flag_ovf), 0);
        op(0, 0, 1, 8'hEE, 0, 0);
        check("R3 level held", int'(level), 24);
        check("R3 ovf flag", int'(flag_ovf), 1);
        check("R3 ovf irq", int'(irq_reg), 6);
        read_irq();
        check("R8 cleared", int'(irq_reg), 0);

        // R6 low watermark (transmit)
        tx_mode = 1'b1; #1;
        check("R7 high flag off in tx", int'(flag_high), 0);
        check("R6 low flag off at 24", int'(flag_low), 0);
        for (int i = 0; i < 17; i++) op(0, 0, 0, 0, 0, 1);
        check("R6 level 7", int'(level), 7);
        check("R6 no low irq at 7", int'(irq_reg), 0);
        check("R6 no low flag at 7", int'(flag_low), 0);
        op(0, 0, 0, 0, 0, 1);
        check("R6 low flag at 6", int'(flag_low), 1);
        check("R6 low irq", int'(irq_reg), 1);
        for (int i = 0; i < 6; i++) op(0, 0, 0, 0, 1, 0);
        check("R6 low flag at 0", int'(flag_low), 1);
        check("R5 drained", int'(level), 0);
        check("R3 ovf sticky", int'(flag_ovf), 1);

        // R1 enable low
        op(1, 8'h77, 0, 0, 0, 0);
        enable = 1'b0;
        op(0, 0, 0, 0, 1, 0);
        enable = 1'b1;
        sb_q.delete();
        check("R1 level after enable low", int'(level), 0);
        check("R1 irq_reg after enable low", int'(irq_reg), 0);
        check("R1 ovf after enable low", int'(flag_ovf), 0);

        // R2 after flush: fresh ordering
        op(1, 8'hC1, 0, 0, 0, 0);
        op(0, 0, 1, 8'hC2, 0, 0);
        op(0, 0, 0, 0, 1, 0);
        op(0, 0, 0, 0, 1, 0);
        check("R2 scoreboard empty", sb_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule